// File: doc/BRIEF.md
# Two-Slot Elastic Pipeline Stage

This block is one stage of a synchronous elastic pipeline. It sits between an upstream channel and a downstream channel. Each channel carries a data word, a valid flag that travels with the data, and a stop flag that travels back toward the producer. A word moves across a channel in a cycle where valid is high and stop is low. While valid is high and stop is high, the producer must keep its word and its valid flag unchanged.

The stage stores words in two halves. Each half has its own load enable, and a small occupancy controller drives both enables. The head half always drives the output. The spare half catches the one extra word that can arrive in the cycle the output becomes blocked. Because the stage has two slots, the stop sent upstream is a plain register that depends only on how many words the stage holds. Back-pressure therefore moves back one stage per cycle and never forms a long combinational path through a chain of stages. A parameter chooses the state after reset. The stage can start empty (a bubble), or it can start holding one valid word whose value is also a parameter (a token).

Top module: `elastic_stage2`

## Requirements
- R1: With the bubble reset option (INIT_TOKEN=0), the cycle after reset shows dn_valid=0 and up_stop=0.
- R2: With the token reset option (INIT_TOKEN=1), the cycle after reset shows dn_valid=1, dn_data=INIT_DATA and up_stop=0. This word is handed downstream at the first edge where dn_stop is low, and dn_valid is then 0 if nothing else was accepted.
- R3: The stage accepts a word at a clock edge where up_valid=1 and up_stop=0. It hands a word downstream at an edge where dn_valid=1 and dn_stop=0.
- R4: A word accepted into an empty stage appears on dn_valid/dn_data one cycle later.
- R5: up_stop is a registered output. It is 1 exactly when the stage holds two words, and it never rises in the cycle after the stage was empty.
- R6: When the stage holds one word and dn_stop=1, it still accepts one more word. up_stop is 1 in the next cycle.
- R7: While dn_valid=1 and dn_stop=1, the next cycle keeps dn_valid=1 and dn_data unchanged.
- R8: Under any pattern of up_valid and dn_stop, the words leave in the order they were accepted. No word is lost and no word is duplicated.
- R9: With up_valid held at 1 and dn_stop held at 0, the stage moves one word per cycle and up_stop stays 0.
- R10: A full stage released with dn_stop=0 delivers both words on consecutive cycles. up_stop falls after the first word leaves and dn_valid falls after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream word is valid |
| up_data | input | DATA_W | Upstream word |
| up_stop | output | 1 | Back-pressure to the upstream producer (registered) |
| dn_valid | output | 1 | Output word is valid |
| dn_data | output | DATA_W | Output word, driven by the head half |
| dn_stop | input | 1 | Back-pressure from the downstream consumer |

## Verification
The hardest case to reach is a word arriving in the same cycle the output becomes blocked. This happens with one word held, up_valid high and dn_stop rising at the same time. The spare half must catch the word, and the stage must later hand it over to the head half without reordering. A directed sequence sets up this case exactly. Long random phases then vary the stop and valid densities from none to nearly always. They go through the full, draining and one-in-one-out transitions many times, and a reference queue compares the delivered stream with bubbles removed.

// File: rtl/elastic_pkg.sv
package elastic_pkg;

  typedef enum logic [1:0] {
    OCC_NONE = 2'd0,
    OCC_ONE  = 2'd1,
    OCC_TWO  = 2'd2
  } occ_e;

  typedef struct packed {
    logic head_en;
    logic spare_en;
    logic head_from_spare;
  } half_ctl_t;

  localparam int unsigned NUM_HALVES = 2;

endpackage

// File: rtl/es_half.sv
module es_half #(
  parameter int unsigned         W       = 8,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (en) q <= d;
  end

endmodule

// File: rtl/es_ctrl.sv
module es_ctrl
  import elastic_pkg::*;
#(
  parameter bit INIT_TOKEN = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      up_valid,
  input  logic      dn_stop,
  output half_ctl_t ctl,
  output logic      dn_valid,
  output logic      up_stop
);

  localparam occ_e OCC_RESET = INIT_TOKEN ? OCC_ONE : OCC_NONE;

  occ_e occ_q, occ_nxt;
  logic take_in, give_out;

  assign take_in  = up_valid & ~up_stop;
  assign give_out = dn_valid & ~dn_stop;

  always_comb begin
    occ_nxt             = occ_q;
    ctl.head_en         = 1'b0;
    ctl.spare_en        = 1'b0;
    ctl.head_from_spare = 1'b0;
    unique case (occ_q)
      OCC_NONE: begin
        if (take_in) begin
          ctl.head_en = 1'b1;
          occ_nxt     = OCC_ONE;
        end
      end
      OCC_ONE: begin
        if (take_in && give_out) begin
          ctl.head_en = 1'b1;
        end else if (take_in) begin
          ctl.spare_en = 1'b1;
          occ_nxt      = OCC_TWO;
        end else if (give_out) begin
          occ_nxt = OCC_NONE;
        end
      end
      OCC_TWO: begin
        if (give_out) begin
          ctl.head_en         = 1'b1;
          ctl.head_from_spare = 1'b1;
          occ_nxt             = OCC_ONE;
        end
      end
      default: occ_nxt = OCC_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q    <= OCC_RESET;
      dn_valid <= INIT_TOKEN;
      up_stop  <= 1'b0;
    end else begin
      occ_q    <= occ_nxt;
      dn_valid <= (occ_nxt != OCC_NONE);
      up_stop  <= (occ_nxt == OCC_TWO);
    end
  end

endmodule

// File: rtl/elastic_stage2.sv
module elastic_stage2
  import elastic_pkg::*;
#(
  parameter int unsigned        DATA_W     = 8,
  parameter bit                 INIT_TOKEN = 1'b0,
  parameter logic [DATA_W-1:0]  INIT_DATA  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  input  logic [DATA_W-1:0] up_data,
  output logic              up_stop,
  output logic              dn_valid,
  output logic [DATA_W-1:0] dn_data,
  input  logic              dn_stop
);

  localparam int unsigned HEAD  = 0;
  localparam int unsigned SPARE = 1;

  half_ctl_t         ctl;
  logic [DATA_W-1:0] half_d  [NUM_HALVES];
  logic [DATA_W-1:0] half_q  [NUM_HALVES];
  logic              half_en [NUM_HALVES];

  es_ctrl #(.INIT_TOKEN(INIT_TOKEN)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .up_valid (up_valid),
    .dn_stop  (dn_stop),
    .ctl      (ctl),
    .dn_valid (dn_valid),
    .up_stop  (up_stop)
  );

  always_comb begin
    half_d[HEAD]   = ctl.head_from_spare ? half_q[SPARE] : up_data;
    half_d[SPARE]  = up_data;
    half_en[HEAD]  = ctl.head_en;
    half_en[SPARE] = ctl.spare_en;
  end

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    localparam logic [DATA_W-1:0] RV =
      (g == HEAD && INIT_TOKEN) ? INIT_DATA : {DATA_W{1'b0}};
    es_half #(.W(DATA_W), .RST_VAL(RV)) u_half (
      .clk (clk),
      .rst (rst),
      .en  (half_en[g]),
      .d   (half_d[g]),
      .q   (half_q[g])
    );
  end

  assign dn_data = half_q[HEAD];

endmodule

// File: rtl/elastic_stage2_chk.sv
module elastic_stage2_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter bit          INIT_TOKEN = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              up_valid,
  input logic              up_stop,
  input logic              dn_valid,
  input logic [DATA_W-1:0] dn_data,
  input logic              dn_stop
);

  // R1, R2: state right after reset
  a_r1_r2_reset_state: assert property (@(posedge clk)
    rst |=> (dn_valid == INIT_TOKEN) && !up_stop);

  // R7: a blocked output word is held
  a_r7_hold_blocked: assert property (@(posedge clk) disable iff (rst)
    dn_valid && dn_stop |=> dn_valid && $stable(dn_data));

  // R5: full implies something to present
  a_r5_full_has_word: assert property (@(posedge clk) disable iff (rst)
    up_stop |-> dn_valid);

  // R5: empty cannot become full in one cycle
  a_r5_no_jump_full: assert property (@(posedge clk) disable iff (rst)
    !dn_valid |=> !up_stop);

  // R6: one held, blocked output, new word accepted -> full
  a_r6_absorb_one: assert property (@(posedge clk) disable iff (rst)
    dn_valid && dn_stop && up_valid && !up_stop |=> up_stop);

  // R9: streaming without stop never raises back-pressure
  a_r9_stream_free: assert property (@(posedge clk) disable iff (rst)
    up_valid && !up_stop && !dn_stop |=> !up_stop);

endmodule

bind elastic_stage2 elastic_stage2_chk #(
  .DATA_W     (DATA_W),
  .INIT_TOKEN (INIT_TOKEN)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .up_valid (up_valid),
  .up_stop  (up_stop),
  .dn_valid (dn_valid),
  .dn_data  (dn_data),
  .dn_stop  (dn_stop)
);

// File: tb/test_elastic_stage2.sv
module test_elastic_stage2;

  localparam int unsigned W = 8;
  localparam logic [W-1:0] TOK_VAL = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         up_valid = 1'b0;
  logic [W-1:0] up_data  = '0;
  logic         dn_stop  = 1'b1;
  logic         up_stop, dn_valid;
  logic [W-1:0] dn_data;

  logic         t_stop = 1'b1;
  logic         t_upstop, t_valid;
  logic [W-1:0] t_data;

  elastic_stage2 #(.DATA_W(W), .INIT_TOKEN(1'b0)) i_elastic_stage2 (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_data(up_data),
    .up_stop(up_stop), .dn_valid(dn_valid), .dn_data(dn_data),
    .dn_stop(dn_stop));

  elastic_stage2 #(.DATA_W(W), .INIT_TOKEN(1'b1), .INIT_DATA(TOK_VAL))
    i_elastic_stage2_tok (
    .clk(clk), .rst(rst), .up_valid(1'b0), .up_data('0),
    .up_stop(t_upstop), .dn_valid(t_valid), .dn_data(t_data),
    .dn_stop(t_stop));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [W-1:0] ref_q[$];

  task automatic chk(input bit ok, input string req,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // driver: apply inputs after an edge, push accepted words at the negedge
  task automatic drive(input logic v, input logic [W-1:0] d, input logic s);
    @(posedge clk); #1;
    up_valid = v; up_data = d; dn_stop = s;
    @(negedge clk);
    if (v && !up_stop) ref_q.push_back(d);
  endtask

  // monitor: R3, R8 ordering and R7 holding
  logic         hold_p = 1'b0;
  logic [W-1:0] hold_d = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_p) begin
        chk(dn_valid && dn_data == hold_d, "R7", {dn_valid, dn_data}, {1'b1, hold_d});
      end
      if (dn_valid && !dn_stop) begin
        if (ref_q.size() == 0) begin
          chk(1'b0, "R8 extra word", dn_data, 0);
        end else begin
          logic [W-1:0] e;
          e = ref_q.pop_front();
          chk(dn_data == e, "R8/R3 order", dn_data, e);
        end
      end
      hold_p = dn_valid && dn_stop;
      hold_d = dn_data;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic         cv;
    logic [W-1:0] cd;
    logic         cs;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1, R2 reset states
    drive(1'b0, '0, 1'b1);
    chk(dn_valid == 1'b0, "R1 dn_valid", dn_valid, 0);
    chk(up_stop == 1'b0, "R1 up_stop", up_stop, 0);
    chk(t_valid == 1'b1 && t_data == TOK_VAL, "R2 token", {t_valid, t_data}, {1'b1, TOK_VAL});
    chk(t_upstop == 1'b0, "R2 up_stop", t_upstop, 0);
    t_stop = 1'b0;

    // R4 one-cycle latency, R6 absorb, R5 full
    drive(1'b1, 8'h11, 1'b1);
    chk(t_valid == 1'b0, "R2 token consumed", t_valid, 0);
    drive(1'b0, '0, 1'b1);
    chk(dn_valid && dn_data == 8'h11, "R4", {dn_valid, dn_data}, {1'b1, 8'h11});
    chk(up_stop == 1'b0, "R6 room", up_stop, 0);
    drive(1'b1, 8'h22, 1'b1);
    drive(1'b0, '0, 1'b1);
    chk(up_stop == 1'b1, "R6 full after absorb", up_stop, 1);
    chk(dn_data == 8'h11, "R5 head kept", dn_data, 8'h11);

    // R10 drain
    drive(1'b0, '0, 1'b0);
    chk(up_stop == 1'b1, "R5 still full", up_stop, 1);
    drive(1'b0, '0, 1'b0);
    chk(up_stop == 1'b0, "R10 stop falls", up_stop, 0);
    chk(dn_valid && dn_data == 8'h22, "R10 second word", {dn_valid, dn_data}, {1'b1, 8'h22});
    drive(1'b0, '0, 1'b0);
    chk(dn_valid == 1'b0, "R10 empty", dn_valid, 0);

    // R9 full-rate streaming
    for (int i = 0; i < 24; i++) begin
      drive(1'b1, W'(8'h40 + i), 1'b0);
      chk(up_stop == 1'b0, "R9 no stop", up_stop, 0);
      if (i > 0) chk(dn_valid == 1'b1, "R9 valid", dn_valid, 1);
    end
    drive(1'b0, '0, 1'b0);
    drive(1'b0, '0, 1'b0);
    chk(ref_q.size() == 0, "R9 all delivered", ref_q.size(), 0);

    // R8 random phases with protocol-correct sender
    cv = 1'b0; cd = '0;
    for (int ph = 0; ph < 4; ph++) begin
      for (int c = 0; c < 600; c++) begin
        cs = ($urandom_range(0, 99) < ph * 30);
        drive(cv, cd, cs);
        if (!cv || !up_stop) begin
          cv = ($urandom_range(0, 99) < 60 + ph * 10);
          cd = W'($urandom);
        end
      end
    end
    for (int c = 0; c < 8; c++) drive(1'b0, '0, 1'b0);
    if (cv) begin
      // word still being offered was never accepted; nothing to settle
    end
    chk(ref_q.size() == 0, "R8 no word lost", ref_q.size(), 0);
    chk(dn_valid == 1'b0 && up_stop == 1'b0, "R8 idle at end", {dn_valid, up_stop}, 0);

    finish_run();
  end

endmodule